// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the series of column addresses a DRAM-style burst visits, one address per data beat. A start strobe carries the first column of the burst. The burst length and the ordering rule come from a small mode register that is loaded ahead of time. Only the low three column bits are reordered. The bits above them are copied through unchanged for the whole burst.

Two orderings are supported. Sequential order counts upward from the start position and wraps inside the burst-aligned window. Interleaved order XORs the start position with the beat number. A burst is 2, 4 or 8 beats long, and the window covers the low 1, 2 or 3 column bits. Each beat comes out on a registered port with a valid flag, a first-beat flag and a last-beat flag, so that a data-path controller can step its capture or launch logic directly from them.

A new burst is accepted only while no burst is running. The mode that applies to a burst is the one held in the mode register at the clock edge where the burst starts, so changing the mode in the middle of a burst does not alter that burst.

Top module: `burst_col_seq`

## Requirements
- R1: After synchronous reset, `beat_valid`, `beat_first` and `beat_last` are low, and the mode register holds burst length 2 with sequential order.
- R2: A clock edge with `mode_load` high loads the mode register. Code 2'b01 selects length 2, 2'b10 selects length 4, 2'b11 selects length 8, and `mode_ilv` = 1 selects interleaved order (0 selects sequential). A load with code 2'b00 is ignored completely, and the previous mode stays in force.
- R3: In sequential order, beat i has low bits equal to (s + i) mod BL inside the low log2(BL) bits, where s is the start column's value in those bits. Column bits 2..log2(BL) keep their start value.
- R4: In interleaved order, beat i has low bits equal to s XOR i inside the low log2(BL) bits. The other low bits keep their start value.
- R5: Column bits above bit 2 equal those of the start column on every beat of the burst.
- R6: `beat_valid` stays high for exactly BL consecutive cycles. `beat_first` is high only on beat 0 and `beat_last` is high only on beat BL-1.
- R7: `burst_go` is ignored while `beat_valid` is high, including the cycle that shows the last beat. It is accepted on the first edge at which `beat_valid` is low.
- R8: A mode load made during a burst does not change that burst's length or order. It applies from the next accepted burst onward.
- R9: The cycle after an accepted `burst_go`, beat 0 appears with `beat_col` equal to `start_col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_load | input | 1 | Loads the mode register |
| mode_len_code | input | 2 | Burst length code: 01 gives 2, 10 gives 4, 11 gives 8, 00 is reserved |
| mode_ilv | input | 1 | 1 selects interleaved order, 0 selects sequential order |
| burst_go | input | 1 | Burst start request |
| start_col | input | COL_W | First column of the burst |
| beat_valid | output | 1 | A beat column is present |
| beat_col | output | COL_W | Column of the current beat |
| beat_first | output | 1 | Marks beat 0 |
| beat_last | output | 1 | Marks beat BL-1 |

## Verification
If the beat counter or the latched length were wrong, the next burst would show a shortened or extended `beat_valid` window, or a misplaced `beat_last`, within at most eight cycles of its start. If the latched order or start column were wrong, the very next beat would show a wrong low column field or a changed upper field. The table drives every length with both orderings, from start positions that do and do not sit on a window boundary. Directed runs cover reset, the reserved length code, a request held through a burst, and a mode load made in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Width of the reordered low column field (maximum burst 2**IDX_W).
  localparam int IDX_W = 3;
  // Width of the log2(burst length) encoding.
  localparam int LEN_W = 2;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  typedef struct packed {
    logic [LEN_W-1:0] len_log;  // 1, 2 or 3
    order_e           order;
  } mode_t;

  localparam mode_t MODE_RESET = '{len_log: 2'd1, order: ORD_SEQ};

  // Length code to log2(length); 0 marks the reserved code.
  function automatic logic [LEN_W-1:0] len_code_to_log(input logic [1:0] code);
    logic [LEN_W-1:0] r;
    case (code)
      2'b01:   r = 2'd1;
      2'b10:   r = 2'd2;
      2'b11:   r = 2'd3;
      default: r = 2'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bseq_mode_reg.sv
module bseq_mode_reg
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] len_code,
  input  logic       ilv,
  output mode_t      mode_q
);

  logic [LEN_W-1:0] len_dec;
  logic             code_ok;

  assign len_dec = len_code_to_log(len_code);
  assign code_ok = (len_dec != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RESET;
    end else if (load && code_ok) begin
      mode_q.len_log <= len_dec;
      mode_q.order   <= ilv ? ORD_ILV : ORD_SEQ;
    end
  end

  // R2: a load with the reserved code leaves the register untouched
  a_r2_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
    (load && len_code == 2'b00) |=> $stable(mode_q));

  // R2: a valid load takes the requested ordering
  a_r2_order_loaded: assert property (@(posedge clk) disable iff (rst)
    (load && len_code != 2'b00) |=> (mode_q.order == ($past(ilv) ? ORD_ILV : ORD_SEQ)));

  // R2: the stored length is always one of the three legal values
  a_r2_len_legal: assert property (@(posedge clk) disable iff (rst)
    mode_q.len_log != 2'd0);

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [LEN_W-1:0] len_log,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             at_end,
  output logic             at_penult
);

  localparam int CNT_W = IDX_W + 1;

  logic [IDX_W-1:0] last_idx;
  logic [CNT_W-1:0] span;

  assign span      = CNT_W'(1) << len_log;
  assign last_idx  = IDX_W'(span - CNT_W'(1));
  assign at_end    = active && (idx == last_idx);
  assign at_penult = active && (idx == last_idx - IDX_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (launch) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active) begin
      if (at_end) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  // R6: the beat index never runs past the burst's final beat
  a_r6_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    active |-> (idx <= last_idx));

  // R6: a running burst that is not at its end keeps running and steps by one
  a_r6_idx_steps: assert property (@(posedge clk) disable iff (rst)
    (active && !at_end && !launch) |=> (active && idx == $past(idx) + IDX_W'(1)));

endmodule

// File: rtl/bseq_permute.sv
module bseq_permute
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [IDX_W-1:0] idx,
  input  logic [LEN_W-1:0] len_log,
  input  order_e           order,
  output logic [COL_W-1:0] col
);

  localparam int HI_W = COL_W - IDX_W;

  logic [IDX_W-1:0] lo, lo_sum, lo_xor, lo_out;

  assign lo     = base[IDX_W-1:0];
  assign lo_sum = lo + idx;
  assign lo_xor = lo ^ idx;

  // Each low bit is either inside the burst window (reordered) or above it (held).
  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    logic in_win;
    assign in_win    = (b < int'(len_log));
    assign lo_out[b] = in_win ? ((order == ORD_ILV) ? lo_xor[b] : lo_sum[b]) : lo[b];
  end

  if (HI_W > 0) begin : g_hi
    assign col = {base[COL_W-1:IDX_W], lo_out};
  end else begin : g_nohi
    assign col = lo_out[COL_W-1:0];
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_load,
  input  logic [1:0]       mode_len_code,
  input  logic             mode_ilv,
  input  logic             burst_go,
  input  logic [COL_W-1:0] start_col,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_first,
  output logic             beat_last
);

  localparam int HI_W = COL_W - IDX_W;

  mode_t            mode_q;
  mode_t            run_mode;
  logic [COL_W-1:0] run_base;
  logic             launch;
  logic             active;
  logic [IDX_W-1:0] idx;
  logic             at_end;
  logic             at_penult;
  logic [IDX_W-1:0] next_idx;
  logic [COL_W-1:0] next_col;

  bseq_mode_reg u_mode (
    .clk      (clk),
    .rst      (rst),
    .load     (mode_load),
    .len_code (mode_len_code),
    .ilv      (mode_ilv),
    .mode_q   (mode_q)
  );

  // Requests are taken only when no burst is running.
  assign launch = burst_go && !active;

  // Start column and mode are frozen for the burst at launch.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_mode <= MODE_RESET;
      run_base <= '0;
    end else if (launch) begin
      run_mode <= mode_q;
      run_base <= start_col;
    end
  end

  bseq_beat_ctr u_ctr (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .len_log   (run_mode.len_log),
    .active    (active),
    .idx       (idx),
    .at_end    (at_end),
    .at_penult (at_penult)
  );

  assign next_idx = idx + IDX_W'(1);

  bseq_permute #(.COL_W(COL_W)) u_perm (
    .base    (run_base),
    .idx     (next_idx),
    .len_log (run_mode.len_log),
    .order   (run_mode.order),
    .col     (next_col)
  );

  // Registered beat outputs, aligned with the counter's active flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      beat_col   <= '0;
      beat_first <= 1'b0;
      beat_last  <= 1'b0;
    end else if (launch) begin
      beat_col   <= start_col;
      beat_first <= 1'b1;
      beat_last  <= 1'b0;
    end else if (active && !at_end) begin
      beat_col   <= next_col;
      beat_first <= 1'b0;
      beat_last  <= at_penult;
    end else begin
      beat_first <= 1'b0;
      beat_last  <= 1'b0;
    end
  end

  assign beat_valid = active;

  // R9: an accepted request shows beat 0 with the start column one cycle later
  a_r9_launch_beat0: assert property (@(posedge clk) disable iff (rst)
    (burst_go && !beat_valid) |=> (beat_valid && beat_first && beat_col == $past(start_col)));

  // R6: the first flag only accompanies a valid beat
  a_r6_first_valid: assert property (@(posedge clk) disable iff (rst)
    beat_first |-> beat_valid);

  // R6: the last flag only accompanies a valid beat, and the burst ends after it
  a_r6_last_valid: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_valid);
  a_r6_last_ends: assert property (@(posedge clk) disable iff (rst)
    beat_last |=> !beat_valid);

  // R7: a running burst continues past any request until its last beat
  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_last) |=> (beat_valid && !beat_first));

  // R5: the upper column field holds steady inside a burst
  if (HI_W > 0) begin : g_hi_chk
    a_r5_upper_held: assert property (@(posedge clk) disable iff (rst)
      (beat_valid && !beat_last) |=>
        (beat_col[COL_W-1:IDX_W] == $past(beat_col[COL_W-1:IDX_W])));
  end

endmodule

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/1ps
module tb_burst_col_seq;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mode_load = 1'b0;
  logic [1:0]       mode_len_code = 2'b00;
  logic             mode_ilv = 1'b0;
  logic             burst_go = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             beat_valid;
  logic [COL_W-1:0] beat_col;
  logic             beat_first;
  logic             beat_last;

  always #5 clk = ~clk;  // 100 MHz

  burst_col_seq #(.COL_W(COL_W)) dut (
    .clk           (clk),
    .rst           (rst),
    .mode_load     (mode_load),
    .mode_len_code (mode_len_code),
    .mode_ilv      (mode_ilv),
    .burst_go      (burst_go),
    .start_col     (start_col),
    .beat_valid    (beat_valid),
    .beat_col      (beat_col),
    .beat_first    (beat_first),
    .beat_last     (beat_last)
  );

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  typedef struct packed {
    logic [1:0]       code;  // 01=2, 10=4, 11=8
    logic             ilv;   // 1 = interleaved
    logic [COL_W-1:0] col;
    logic [23:0]      seq;   // expected low 3 bits of beat i at [3*i +: 3]
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 1'b0, 10'h0A5, {18'd0, 3'd4, 3'd5}},
    '{2'b01, 1'b1, 10'h3FA, {18'd0, 3'd3, 3'd2}},
    '{2'b10, 1'b0, 10'h155, {12'd0, 3'd4, 3'd7, 3'd6, 3'd5}},
    '{2'b10, 1'b1, 10'h2AD, {12'd0, 3'd6, 3'd7, 3'd4, 3'd5}},
    '{2'b11, 1'b0, 10'h1FB, {3'd2, 3'd1, 3'd0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3}},
    '{2'b11, 1'b1, 10'h003, {3'd4, 3'd5, 3'd6, 3'd7, 3'd0, 3'd1, 3'd2, 3'd3}},
    '{2'b11, 1'b1, 10'h30E, {3'd1, 3'd0, 3'd3, 3'd2, 3'd5, 3'd4, 3'd7, 3'd6}},
    '{2'b11, 1'b0, 10'h200, {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}},
    '{2'b10, 1'b1, 10'h0FF, {12'd0, 3'd4, 3'd5, 3'd6, 3'd7}}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic load_mode(input logic [1:0] code, input logic ilv);
    @(negedge clk);
    mode_load = 1'b1; mode_len_code = code; mode_ilv = ilv;
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  // Check one beat at the current negedge.
  task automatic chk_beat(input logic [COL_W-1:0] exp_col, input bit exp_first,
                          input bit exp_last, input string tag);
    chk(beat_valid == 1'b1, {tag, " R6 valid"}, 32'(beat_valid), 32'd1);
    chk(beat_col == exp_col, {tag, " col"}, 32'(beat_col), 32'(exp_col));
    chk(beat_first == exp_first, {tag, " R6 first"}, 32'(beat_first), 32'(exp_first));
    chk(beat_last == exp_last, {tag, " R6 last"}, 32'(beat_last), 32'(exp_last));
  endtask

  task automatic run_burst(input logic [COL_W-1:0] col, input logic [23:0] seq,
                           input int len, input string tag);
    @(negedge clk);
    burst_go = 1'b1; start_col = col;
    @(negedge clk);
    burst_go = 1'b0;
    for (int i = 0; i < len; i++) begin
      chk_beat({col[COL_W-1:3], seq[3*i +: 3]}, (i == 0), (i == len - 1), tag);
      @(negedge clk);
    end
    chk(beat_valid == 1'b0, {tag, " R6 ends after BL"}, 32'(beat_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during and right after reset
    chk(beat_valid == 1'b0, "R1 valid in reset", 32'(beat_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(beat_valid == 1'b0, "R1 valid after reset", 32'(beat_valid), 32'd0);
    chk(beat_first == 1'b0, "R1 first after reset", 32'(beat_first), 32'd0);
    chk(beat_last == 1'b0, "R1 last after reset", 32'(beat_last), 32'd0);

    // R1: default mode is length 2 sequential (low bit 1 -> 1,0)
    run_burst(10'h013, {18'd0, 3'd2, 3'd3}, 2, "R1 default mode R9");

    // Table: R3 sequential, R4 interleaved, R5 upper bits carried
    for (int v = 0; v < NV; v++) begin
      load_mode(VECS[v].code, VECS[v].ilv);
      run_burst(VECS[v].col, VECS[v].seq, 2 << (VECS[v].code - 1),
                VECS[v].ilv ? "R4 R5 vec" : "R3 R5 vec");
    end

    // R2: reserved code load is ignored (BL8 interleaved stays)
    load_mode(2'b11, 1'b1);
    load_mode(2'b00, 1'b0);
    run_burst(10'h001, {3'd6, 3'd7, 3'd4, 3'd5, 3'd2, 3'd3, 3'd0, 3'd1}, 8, "R2 reserved code");

    // R7: request held high through a whole burst
    load_mode(2'b10, 1'b0);
    @(negedge clk);
    burst_go = 1'b1; start_col = 10'h004;
    @(negedge clk);
    start_col = 10'h100;
    for (int i = 0; i < 4; i++) begin
      chk_beat({7'h00, 3'(4 + i)}, (i == 0), (i == 3), "R7 held request");
      @(negedge clk);
    end
    chk(beat_valid == 1'b0, "R7 ignored on last beat", 32'(beat_valid), 32'd0);
    @(negedge clk);
    burst_go = 1'b0;
    chk_beat(10'h100, 1'b1, 1'b0, "R7 accepted when idle");
    repeat (5) @(negedge clk);
    chk(beat_valid == 1'b0, "R7 second burst ends", 32'(beat_valid), 32'd0);

    // R8: mode load in mid-burst does not disturb the running burst
    load_mode(2'b10, 1'b0);
    @(negedge clk);
    burst_go = 1'b1; start_col = 10'h001;
    @(negedge clk);
    burst_go = 1'b0;
    chk_beat(10'h001, 1'b1, 1'b0, "R8 beat0");
    mode_load = 1'b1; mode_len_code = 2'b11; mode_ilv = 1'b1;
    @(negedge clk);
    mode_load = 1'b0;
    chk_beat(10'h002, 1'b0, 1'b0, "R8 beat1");
    @(negedge clk);
    chk_beat(10'h003, 1'b0, 1'b0, "R8 beat2");
    @(negedge clk);
    chk_beat(10'h000, 1'b0, 1'b1, "R8 beat3");
    @(negedge clk);
    chk(beat_valid == 1'b0, "R8 old length kept", 32'(beat_valid), 32'd0);
    run_burst(10'h002, {3'd5, 3'd4, 3'd7, 3'd6, 3'd1, 3'd0, 3'd3, 3'd2}, 8, "R8 new mode R4");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule